// File: doc/BRIEF.md
# Reloadable 8-bit Up/Down Timer

This block is an 8-bit counter with a reload register, a mode register and a status register. Software reaches all of them over a small byte-wide register bus. Each count event moves the counter one step. A count event is a one-cycle enable pulse on one of seven internal prescaler taps, or a rising edge on an external count pin. The counter can step up or down. Software chooses the direction through the mode register, or hands the choice to an external pin.

The timer has two modes. In interval mode the counter wraps freely: it goes from 0xFF to 0x00 when counting up, and from 0x00 to 0xFF when counting down. In auto-reload mode each wrap reloads the programmed value instead, so the period runs from 1 to 256 count events.

The counter and the reload register share one bus address. A write there stores the reload value and also loads the counter at once. A read there returns the live count. Every wrap sets a request flag. The interrupt output follows that flag whenever the enable bit is set.

Top module: `updn_timer`

## Requirements
- R1: After reset, address 0 reads 0x00, address 1 (mode) reads 0x18, address 2 (status) reads 0x00 and irqOut is low; the block then counts up in interval mode on tap 0.
- R2: A write to address 0 stores the byte as the reload value and loads it into the counter on the same clock edge; a read of address 0 returns the live count.
- R3: Each count event while counting up adds one to the count; the event that follows a count of 0xFF is an overflow.
- R4: In interval mode (mode bit 7 = 0) an overflow leaves the count at 0x00 and an underflow (the event that follows 0x00 when counting down) leaves it at 0xFF.
- R5: In auto-reload mode (mode bit 7 = 1) an overflow or underflow loads the reload value into the counter; with a reload of 0xFF counting up, every event is an overflow.
- R6: Every overflow or underflow sets the flag, status bit 0; irqOut is high exactly when that flag and the enable (status bit 1) are both 1.
- R7: Writing status with bit 0 = 0 clears the flag and writing bit 0 = 1 leaves it unchanged; status bit 1 is written directly; a wrap in the same cycle as a clearing write leaves the flag set.
- R8: Mode bits 2..0 pick the count source: values 0..6 select tap n of cycTaps, and value 7 selects the rising edges of extCount after a two-flop synchronizer; pulses on sources that are not selected do not move the count.
- R9: Mode bits 6..5 set the direction: 00 up, 01 down, 1x taken from extDir after a two-flop synchronizer (high = down).
- R10: Mode bits 4..3 always read as 1, whatever value is written.
- R11: A write to address 0 in the same cycle as a count event loads the written value, and that event is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 count/reload, 1 mode, 2 status) |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data of the addressed register (combinational) |
| cycTaps | input | 7 | Prescaler taps, each a one-cycle count enable |
| extCount | input | 1 | External count input, asynchronous |
| extDir | input | 1 | External direction pin, asynchronous, high = down |
| irqOut | output | 1 | Interrupt request output |

## Verification
The bench goes after both wrap points in each mode. A design that mixed up the modes would reload in interval mode, or wrap through 0x00 in auto-reload mode. The reload value 0xFF is also exercised: it must overflow on every event, and an off-by-one terminal test would stretch that period to two events. Collisions are driven on purpose: a count event during a counter write, and a wrap during a flag-clearing write. A design with the wrong priority would show a stepped count, or a lost flag and a silent interrupt. Source selection is checked with pulses on taps that are not selected and with a held external input. Logic that counted levels instead of edges, or ignored the selector, would run the count past its expected value.

// File: rtl/updn_timer_pkg.sv
package updn_timer_pkg;

  localparam int CNT_W    = 8;
  localparam int NUM_TAPS = 7;
  localparam int SRC_W    = $clog2(NUM_TAPS + 1);

  // register addresses
  localparam logic [1:0] ADDR_CNT  = 2'd0;
  localparam logic [1:0] ADDR_MODE = 2'd1;
  localparam logic [1:0] ADDR_STS  = 2'd2;

  // mode register field positions
  localparam int MODE_AUTO   = 7;
  localparam int MODE_DIRPIN = 6;
  localparam int MODE_DOWN   = 5;
  localparam logic [7:0] MODE_FIXED_ONES = 8'h18;
  localparam logic [7:0] MODE_RESET      = 8'h18;

  // status register field positions
  localparam int STS_FLAG = 0;
  localparam int STS_EN   = 1;

  typedef struct packed {
    logic tick;      // count event this cycle
    logic countUp;   // direction of the step
    logic wrap;      // event is an overflow or underflow
    logic autoMode;  // reload on wrap
    logic loadBus;   // bus write to counter/reload
  } tmrStrobe_t;

endpackage

// File: rtl/updn_timer_ctrl.sv
module updn_timer_ctrl
  import updn_timer_pkg::*;
#(
  parameter int WIDTH = CNT_W,
  parameter int TAPS  = NUM_TAPS
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [1:0]       addr,
  input  logic [7:0]       wrData,
  input  logic [TAPS-1:0]  cycTaps,
  input  logic             extCount,
  input  logic             extDir,
  input  logic [WIDTH-1:0] count,
  output tmrStrobe_t       strobe,
  output logic [7:0]       modeReg,
  output logic             flagReg,
  output logic             enableReg
);

  localparam int SEL_W = $clog2(TAPS + 1);
  localparam logic [WIDTH-1:0] CNT_MAX = {WIDTH{1'b1}};
  localparam logic [SEL_W-1:0] EXT_SEL = SEL_W'(TAPS);

  logic extSync1, extSync2, extPrev;
  logic dirSync1, dirSync2;
  logic extRise;
  logic modeWrite, stsWrite;
  logic selTick, countUp, atTerm, wrapNow;
  logic [SEL_W-1:0] srcSel;
  logic unusedStsBits;

  assign unusedStsBits = ^wrData[7:2];

  // two-flop synchronizers plus edge detector
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extSync1 <= 1'b0;
      extSync2 <= 1'b0;
      extPrev  <= 1'b0;
      dirSync1 <= 1'b0;
      dirSync2 <= 1'b0;
    end else begin
      extSync1 <= extCount;
      extSync2 <= extSync1;
      extPrev  <= extSync2;
      dirSync1 <= extDir;
      dirSync2 <= dirSync1;
    end
  end

  assign extRise = extSync2 & ~extPrev;

  assign modeWrite = wrEn && (addr == ADDR_MODE);
  assign stsWrite  = wrEn && (addr == ADDR_STS);

  assign srcSel = modeReg[SEL_W-1:0];

  // source selection
  always_comb begin
    selTick = 1'b0;
    for (int i = 0; i < TAPS; i++) begin
      if (srcSel == SEL_W'(i)) selTick = cycTaps[i];
    end
    if (srcSel == EXT_SEL) selTick = extRise;
  end

  // direction selection
  always_comb begin
    if (modeReg[MODE_DIRPIN]) countUp = ~dirSync2;
    else                      countUp = ~modeReg[MODE_DOWN];
  end

  assign atTerm  = countUp ? (count == CNT_MAX) : (count == '0);
  assign wrapNow = selTick && atTerm;

  always_comb begin
    strobe.tick     = selTick;
    strobe.countUp  = countUp;
    strobe.wrap     = wrapNow;
    strobe.autoMode = modeReg[MODE_AUTO];
    strobe.loadBus  = wrEn && (addr == ADDR_CNT);
  end

  // mode register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          modeReg <= MODE_RESET;
    else if (modeWrite) modeReg <= wrData;
  end

  // status: flag and enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagReg   <= 1'b0;
      enableReg <= 1'b0;
    end else begin
      if (stsWrite) enableReg <= wrData[STS_EN];
      if (wrapNow)
        flagReg <= 1'b1;
      else if (stsWrite && !wrData[STS_FLAG])
        flagReg <= 1'b0;
    end
  end

  // R6
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrap |=> flagReg);

  // R7
  flag_clear_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flagReg) |-> $past(stsWrite && !wrData[STS_FLAG]));

  // R8
  wrap_needs_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrap |-> strobe.tick);

endmodule

// File: rtl/updn_timer_dp.sv
module updn_timer_dp
  import updn_timer_pkg::*;
#(
  parameter int WIDTH = CNT_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strobe,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] count
);

  logic [WIDTH-1:0] reloadReg;
  logic [WIDTH-1:0] stepVal;

  assign stepVal = strobe.countUp ? count + WIDTH'(1) : count - WIDTH'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count     <= '0;
      reloadReg <= '0;
    end else if (strobe.loadBus) begin
      count     <= wrData;
      reloadReg <= wrData;
    end else if (strobe.tick) begin
      if (strobe.wrap && strobe.autoMode) count <= reloadReg;
      else                                count <= stepVal;
    end
  end

  // R11
  bus_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadBus |=> count == $past(wrData));

  // R5
  reload_on_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && strobe.wrap && strobe.autoMode && !strobe.loadBus)
      |=> count == $past(reloadReg));

  // R3
  up_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && strobe.countUp && !strobe.wrap && !strobe.loadBus)
      |=> count == $past(count) + WIDTH'(1));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.tick && !strobe.loadBus) |=> $stable(count));

endmodule

// File: rtl/updn_timer.sv
module updn_timer
  import updn_timer_pkg::*;
#(
  parameter int WIDTH = CNT_W,
  parameter int TAPS  = NUM_TAPS
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic [1:0]      addr,
  input  logic [7:0]      wrData,
  output logic [7:0]      rdData,
  input  logic [TAPS-1:0] cycTaps,
  input  logic            extCount,
  input  logic            extDir,
  output logic            irqOut
);

  tmrStrobe_t       strobe;
  logic [WIDTH-1:0] count;
  logic [7:0]       modeReg;
  logic             flagReg;
  logic             enableReg;

  updn_timer_ctrl #(.WIDTH(WIDTH), .TAPS(TAPS)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .addr      (addr),
    .wrData    (wrData),
    .cycTaps   (cycTaps),
    .extCount  (extCount),
    .extDir    (extDir),
    .count     (count),
    .strobe    (strobe),
    .modeReg   (modeReg),
    .flagReg   (flagReg),
    .enableReg (enableReg)
  );

  updn_timer_dp #(.WIDTH(WIDTH)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrData (wrData[WIDTH-1:0]),
    .count  (count)
  );

  always_comb begin
    unique case (addr)
      ADDR_CNT:  rdData = 8'(count);
      ADDR_MODE: rdData = modeReg | MODE_FIXED_ONES;
      ADDR_STS:  rdData = {6'b0, enableReg, flagReg};
      default:   rdData = 8'h00;
    endcase
  end

  assign irqOut = flagReg & enableReg;

  // R6
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> flagReg);

endmodule

// File: tb/updn_timer_bench.sv
`timescale 1ns/1ps
module updn_timer_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic [6:0] cycTaps = 7'h00;
  logic       extCount = 1'b0;
  logic       extDir = 1'b0;
  logic       irqOut;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // reference state
  logic [7:0] mCount = 8'h00, mReload = 8'h00, mMode = 8'h18;
  bit mFlag = 0, mEn = 0;
  bit modelOk = 1;

  always #10 clk = ~clk;

  updn_timer u_updn_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .cycTaps(cycTaps), .extCount(extCount), .extDir(extDir),
    .irqOut(irqOut)
  );

  task automatic checkEq(string tag, logic [7:0] got, logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  function automatic bit modelTick(logic [7:0] m, logic [6:0] t);
    if (m[2:0] == 3'd7) return 1'b0;
    return t[m[2:0]];
  endfunction

  function automatic bit modelUp(logic [7:0] m, logic pin);
    return m[6] ? !pin : !m[5];
  endfunction

  // one bus cycle: drive, let one edge pass, compare at the falling edge
  task automatic cycle(bit wr, logic [1:0] a, logic [7:0] d, logic [6:0] t);
    bit tk, up, wr0;
    wrEn = wr; addr = a; wrData = d; cycTaps = t;
    tk = modelTick(mMode, t);
    up = modelUp(mMode, extDir);
    wr0 = (up ? (mCount == 8'hFF) : (mCount == 8'h00)) && tk;
    if (wr && a == 2'd0) begin
      mCount = d; mReload = d;
    end else if (tk) begin
      if (wr0 && mMode[7]) mCount = mReload;
      else mCount = up ? mCount + 8'd1 : mCount - 8'd1;
    end
    if (wr && a == 2'd1) mMode = d;
    if (wr0) mFlag = 1;
    else if (wr && a == 2'd2 && !d[0]) mFlag = 0;
    if (wr && a == 2'd2) mEn = d[1];
    @(posedge clk);
    @(negedge clk);
    if (modelOk) begin
      if (a == 2'd0) checkEq("R2 R3 R4 R5 count", rdData, mCount);
      checkEq("R6 irq", {7'b0, irqOut}, {7'b0, mFlag & mEn});
    end
    wrEn = 0; cycTaps = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cycle(0, 2'd0, 8'h00, 7'h00);
  endtask

  task automatic readReg(logic [1:0] a, output logic [7:0] v);
    cycle(0, a, 8'h00, 7'h00);
    v = rdData;
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset values
    addr = 2'd0; #1 checkEq("R1 count", rdData, 8'h00);
    addr = 2'd1; #1 checkEq("R1 R10 mode", rdData, 8'h18);
    addr = 2'd2; #1 checkEq("R1 status", rdData, 8'h00);
    checkEq("R1 irq", {7'b0, irqOut}, 8'h00);
    rstN = 1'b1;
    @(negedge clk);

    // R1 R3: default counts up on tap 0
    for (int i = 0; i < 3; i++) cycle(0, 2'd0, 8'h00, 7'h01);
    readReg(2'd0, v); checkEq("R1 R3 default up", v, 8'h03);

    // R2 R4 R6: overflow wraps to 00 and sets flag
    cycle(1, 2'd0, 8'hFE, 7'h00);
    readReg(2'd0, v); checkEq("R2 load", v, 8'hFE);
    cycle(0, 2'd0, 8'h00, 7'h01);
    cycle(0, 2'd0, 8'h00, 7'h01);
    readReg(2'd0, v); checkEq("R4 overflow wrap", v, 8'h00);
    readReg(2'd2, v); checkEq("R6 flag set", v, 8'h01);
    checkEq("R6 irq masked", {7'b0, irqOut}, 8'h00);
    // R7: write 1 to flag does nothing, enable drives irq
    cycle(1, 2'd2, 8'h03, 7'h00);
    readReg(2'd2, v); checkEq("R7 write1 keeps flag", v, 8'h03);
    checkEq("R6 irq on", {7'b0, irqOut}, 8'h01);
    cycle(1, 2'd2, 8'h02, 7'h00);
    readReg(2'd2, v); checkEq("R7 flag cleared", v, 8'h02);

    // R4 R9: interval down wraps to FF
    cycle(1, 2'd1, 8'h20, 7'h00);
    cycle(1, 2'd0, 8'h01, 7'h00);
    cycle(0, 2'd0, 8'h00, 7'h01);
    cycle(0, 2'd0, 8'h00, 7'h01);
    readReg(2'd0, v); checkEq("R4 R9 underflow wrap", v, 8'hFF);

    // R5 auto-reload up and down
    cycle(1, 2'd1, 8'h80, 7'h00);
    cycle(1, 2'd0, 8'hFD, 7'h00);
    for (int i = 0; i < 3; i++) cycle(0, 2'd0, 8'h00, 7'h01);
    readReg(2'd0, v); checkEq("R5 reload up", v, 8'hFD);
    cycle(1, 2'd1, 8'hA0, 7'h00);
    cycle(1, 2'd0, 8'h02, 7'h00);
    for (int i = 0; i < 3; i++) cycle(0, 2'd0, 8'h00, 7'h01);
    readReg(2'd0, v); checkEq("R5 reload down", v, 8'h02);
    // R5 period of one event
    cycle(1, 2'd1, 8'h80, 7'h00);
    cycle(1, 2'd0, 8'hFF, 7'h00);
    cycle(1, 2'd2, 8'h00, 7'h00);
    cycle(0, 2'd0, 8'h00, 7'h01);
    readReg(2'd2, v); checkEq("R5 reload FF wraps", v, 8'h01);
    readReg(2'd0, v); checkEq("R5 reload FF count", v, 8'hFF);

    // R7 set wins over clear
    cycle(1, 2'd2, 8'h00, 7'h01);
    readReg(2'd2, v); checkEq("R7 set wins", v, 8'h01);

    // R8 tap select, others ignored; R10 fixed bits
    cycle(1, 2'd1, 8'h03, 7'h00);
    readReg(2'd1, v); checkEq("R10 mode bits", v, 8'h1B);
    cycle(1, 2'd0, 8'h30, 7'h00);
    cycle(0, 2'd0, 8'h00, 7'h77);
    readReg(2'd0, v); checkEq("R8 unselected taps", v, 8'h30);
    cycle(0, 2'd0, 8'h00, 7'h08);
    readReg(2'd0, v); checkEq("R8 tap 3", v, 8'h31);

    // R11 write beats tick
    cycle(1, 2'd0, 8'h40, 7'h08);
    readReg(2'd0, v); checkEq("R11 write wins", v, 8'h40);

    // R8 external rising edges
    cycle(1, 2'd1, 8'h07, 7'h00);
    cycle(1, 2'd0, 8'h10, 7'h00);
    modelOk = 0;
    for (int p = 0; p < 3; p++) begin
      extCount = 1'b1;
      for (int i = 0; i < 5; i++) cycle(0, 2'd0, 8'h00, 7'h7F);
      extCount = 1'b0;
      for (int i = 0; i < 5; i++) cycle(0, 2'd0, 8'h00, 7'h7F);
    end
    readReg(2'd0, v); checkEq("R8 external edges", v, 8'h13);

    // R9 direction from pin
    cycle(1, 2'd1, 8'h40, 7'h00);
    cycle(1, 2'd0, 8'h20, 7'h00);
    modelOk = 1;
    extDir = 1'b1;
    idle(4);
    for (int i = 0; i < 3; i++) cycle(0, 2'd0, 8'h00, 7'h01);
    readReg(2'd0, v); checkEq("R9 pin down", v, 8'h1D);
    extDir = 1'b0;
    idle(4);
    for (int i = 0; i < 2; i++) cycle(0, 2'd0, 8'h00, 7'h01);
    readReg(2'd0, v); checkEq("R9 pin up", v, 8'h1F);

    // constrained random: R3 R4 R5 R6 R7 R8 R9 R11 against the model
    void'($urandom(32'h5EED1234));
    for (int n = 0; n < 4000; n++) begin
      int r;
      logic [7:0] d;
      r = $urandom_range(0, 99);
      d = 8'($urandom);
      if (r < 4)       cycle(1, 2'd1, {d[7], 1'b0, d[5], 2'b00, 3'($urandom_range(0, 6))}, 7'h00);
      else if (r < 8)  cycle(1, 2'd0, d, 7'($urandom));
      else if (r < 11) cycle(1, 2'd2, d, 7'($urandom));
      else             cycle(0, 2'd0, 8'h00, 7'($urandom));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule